// File: doc/BRIEF.md
# PWM Output Fault Override Stage

This block sits between two PWM generator outputs and the device pins and conditions the final waveforms. Four external fault lines are first brought into the clock domain by a two-flop synchronizer. Each line then gets its own polarity correction. A per-generator source mask decides which corrected lines can trip this output pair.

A detected fault can be held in two ways. It can stay latched until software pulses a clear. It can also be stretched so that it stays active for a programmable number of clocks after the last cycle the fault was seen. While the fault is active, each output is replaced by its own programmed safe level. After that override, a per-output inversion is applied, and then a per-output enable gates the pin to 0.

Two kinds of status are reported. One is the synchronized, polarity-corrected level of every input, whether or not it is masked. The other is a sticky flag that records any masked fault and is cleared by the same clear pulse that releases the latch.

Top module: `pwm_fault_stage`

## Requirements
- R1: A level on `flt_in` sampled at rising edge k appears on `flt_raw` after edge k+2 (two synchronizer flops plus a status register). A masked fault that is seen on `flt_raw` after edge k+2 also raises `flt_active` after that same edge.
- R2: Fault sense: `flt_raw[i]` is 1 (asserted) when `flt_in[i]` equals NOT `cfg_sense[i]`. With `cfg_sense[i]`=1 the input is asserted low; with `cfg_sense[i]`=0 it is asserted high.
- R3: Only inputs whose bit in `cfg_src_mask` is 1 can raise `flt_active` or `flt_sticky`. An asserted, unmasked input has no effect on either of them or on `pwm_out`.
- R4: With `cfg_latch`=0 and `cfg_stretch`=0, `flt_active` is 1 exactly in the cycles that follow an edge at which a masked, asserted, synchronized input was present. It follows the input with the R1 latency.
- R5: With `cfg_latch`=1, a detected fault keeps `flt_active` at 1 after the input deasserts. The fault is released only by a `fault_clr` pulse taken at an edge where no masked fault is present. A fault present at that edge wins over the clear.
- R6: With `cfg_stretch`=1 and period P=`cfg_min_period`, `flt_active` stays 1 for P more cycles after the last cycle in which the masked fault was active on its own. A new detection restarts the count. P=0 behaves as R4.
- R7: With both latch and stretch enabled, `flt_active` falls only once the latch has been cleared and the stretch count has also run out.
- R8: `flt_sticky` is set by any masked fault, stays set regardless of the hold modes, and is cleared by `fault_clr` unless a masked fault is present at the same edge.
- R9: `pwm_out[j]` is registered. At edge e it takes `cfg_safe_val[j]` if `flt_active` was 1 before e, and otherwise `pwm_in[j]`, then applies R10 and R11.
- R10: Inversion is applied after the override. An enabled output with `cfg_out_inv[j]`=1 shows the complement of the selected level, including the safe level.
- R11: An output with `cfg_out_en[j]`=0 drives 0 after the next edge, whatever the fault, safe value or inversion settings.
- R12: Synchronous active-high reset clears `pwm_out`, `flt_raw`, `flt_active`, `flt_sticky`, the latch, the stretch counter and the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 2 | Raw generator waveforms |
| flt_in | input | 4 | Asynchronous external fault lines |
| cfg_sense | input | 4 | Per-input polarity, 1 = asserted low |
| cfg_src_mask | input | 4 | Inputs allowed to fault this pair |
| cfg_latch | input | 1 | Hold fault until cleared |
| cfg_stretch | input | 1 | Enable minimum fault duration |
| cfg_min_period | input | 16 | Stretch length in clocks |
| cfg_safe_val | input | 2 | Per-output level forced during a fault |
| cfg_out_en | input | 2 | Per-output enable |
| cfg_out_inv | input | 2 | Per-output inversion |
| fault_clr | input | 1 | Pulse releasing latch and sticky flag |
| pwm_out | output | 2 | Pin-level waveforms |
| flt_raw | output | 4 | Synchronized, polarity-corrected inputs |
| flt_active | output | 1 | Fault override currently in force |
| flt_sticky | output | 1 | A masked fault has occurred since the last clear |

## Verification
Directed sequences come first. One places an asserted fault on an unmasked line, which shows the mask really blocks it. Single-cycle pulses, long faults and clears issued during a fault separate follow mode, latch, stretch and their combination from one another. Flipping the sense bits during steady inputs tells polarity apart from masking. Constrained-random phases then vary every configuration bit, stretch lengths from 0 to 11, sparse fault toggles, clear pulses and random generator waveforms. A cycle reference model computes every output after each edge, so off-by-one latency and priority errors between a clear and a coincident fault show up.

// File: rtl/pwm_fault_pkg.sv
package pwm_fault_pkg;
  localparam int FLT_LINES = 4;
  localparam int OUT_LINES = 2;
  localparam int PERIOD_W  = 16;

  // Reduce masked, polarity-corrected fault lines to one hit bit.
  function automatic logic masked_hit(input logic [FLT_LINES-1:0] asserted,
                                      input logic [FLT_LINES-1:0] mask);
    return |(asserted & mask);
  endfunction
endpackage

// File: rtl/pwm_flt_sync.sv
module pwm_flt_sync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  input  logic [N-1:0] sense,
  output logic [N-1:0] asserted,
  output logic [N-1:0] raw_q
);
  logic [N-1:0] meta_q;
  logic [N-1:0] sync_q;

  for (genvar i = 0; i < N; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q[i] <= 1'b0;
        sync_q[i] <= 1'b0;
        raw_q[i]  <= 1'b0;
      end else begin
        meta_q[i] <= din[i];
        sync_q[i] <= meta_q[i];
        raw_q[i]  <= sync_q[i] ^ sense[i];
      end
    end
    assign asserted[i] = sync_q[i] ^ sense[i];
  end
endmodule

// File: rtl/pwm_fault_hold.sv
module pwm_fault_hold
  import pwm_fault_pkg::*;
#(
  parameter int N   = 4,
  parameter int PW  = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  asserted,
  input  logic [N-1:0]  mask,
  input  logic          latch_en,
  input  logic          stretch_en,
  input  logic [PW-1:0] min_period,
  input  logic          clr,
  output logic          active_q,
  output logic          sticky_q
);
  logic          hit;
  logic          latch_q;
  logic [PW-1:0] cnt_q;
  logic          cnt_live;

  assign hit      = masked_hit(asserted, mask);
  assign cnt_live = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      latch_q  <= 1'b0;
      cnt_q    <= '0;
      sticky_q <= 1'b0;
    end else begin
      active_q <= hit | (latch_en & latch_q) | (stretch_en & cnt_live);
      latch_q  <= latch_en & (hit | (latch_q & ~clr));
      sticky_q <= hit | (sticky_q & ~clr);
      if (!stretch_en)   cnt_q <= '0;
      else if (hit)      cnt_q <= min_period;
      else if (cnt_live) cnt_q <= cnt_q - 1'b1;
    end
  end

  // R4
  hit_raises_active_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> active_q);
  // R5
  latch_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (latch_en && latch_q && !hit && !clr) |=> latch_q);
  // R6
  stretch_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (stretch_en && cnt_live) |=> active_q);
  // R8
  sticky_set_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> sticky_q);
  // R8
  sticky_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !hit) |=> !sticky_q);
endmodule

// File: rtl/pwm_out_cond.sv
module pwm_out_cond #(
  parameter int M = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [M-1:0] gen_in,
  input  logic         fault_on,
  input  logic [M-1:0] safe_val,
  input  logic [M-1:0] out_en,
  input  logic [M-1:0] out_inv,
  output logic [M-1:0] pin_q
);
  for (genvar j = 0; j < M; j++) begin : g_out
    logic sel;
    assign sel = fault_on ? safe_val[j] : gen_in[j];
    always_ff @(posedge clk) begin
      if (rst) pin_q[j] <= 1'b0;
      else     pin_q[j] <= out_en[j] & (sel ^ out_inv[j]);
    end

    // R11
    disabled_low_chk: assert property (@(posedge clk) disable iff (rst)
      !out_en[j] |=> !pin_q[j]);
    // R9
    safe_override_chk: assert property (@(posedge clk) disable iff (rst)
      (fault_on && out_en[j]) |=> (pin_q[j] == $past(safe_val[j] ^ out_inv[j])));
  end
endmodule

// File: rtl/pwm_fault_stage.sv
module pwm_fault_stage
  import pwm_fault_pkg::*;
#(
  parameter int N  = FLT_LINES,
  parameter int M  = OUT_LINES,
  parameter int PW = PERIOD_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [M-1:0]  pwm_in,
  input  logic [N-1:0]  flt_in,
  input  logic [N-1:0]  cfg_sense,
  input  logic [N-1:0]  cfg_src_mask,
  input  logic          cfg_latch,
  input  logic          cfg_stretch,
  input  logic [PW-1:0] cfg_min_period,
  input  logic [M-1:0]  cfg_safe_val,
  input  logic [M-1:0]  cfg_out_en,
  input  logic [M-1:0]  cfg_out_inv,
  input  logic          fault_clr,
  output logic [M-1:0]  pwm_out,
  output logic [N-1:0]  flt_raw,
  output logic          flt_active,
  output logic          flt_sticky
);
  logic [N-1:0] asserted;

  pwm_flt_sync #(.N(N)) i_sync (
    .clk(clk), .rst(rst), .din(flt_in), .sense(cfg_sense),
    .asserted(asserted), .raw_q(flt_raw)
  );

  pwm_fault_hold #(.N(N), .PW(PW)) i_hold (
    .clk(clk), .rst(rst), .asserted(asserted), .mask(cfg_src_mask),
    .latch_en(cfg_latch), .stretch_en(cfg_stretch), .min_period(cfg_min_period),
    .clr(fault_clr), .active_q(flt_active), .sticky_q(flt_sticky)
  );

  pwm_out_cond #(.M(M)) i_out (
    .clk(clk), .rst(rst), .gen_in(pwm_in), .fault_on(flt_active),
    .safe_val(cfg_safe_val), .out_en(cfg_out_en), .out_inv(cfg_out_inv),
    .pin_q(pwm_out)
  );

  // R3
  unmasked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((flt_raw & cfg_src_mask) == '0 && !cfg_latch && !cfg_stretch
     && $stable(cfg_src_mask) && $stable(cfg_sense)) |-> !flt_active);
endmodule

// File: tb/test_pwm_fault_stage.sv
`timescale 1ns/1ps
module test_pwm_fault_stage;
  localparam int N = 4;
  localparam int M = 2;
  localparam int PW = 16;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [M-1:0] pwm_in = '0;
  logic [N-1:0] flt_in = '0, cfg_sense = '0, cfg_src_mask = '0;
  logic cfg_latch = 1'b0, cfg_stretch = 1'b0, fault_clr = 1'b0;
  logic [PW-1:0] cfg_min_period = '0;
  logic [M-1:0] cfg_safe_val = '0, cfg_out_en = '0, cfg_out_inv = '0;
  logic [M-1:0] pwm_out;
  logic [N-1:0] flt_raw;
  logic flt_active, flt_sticky;

  int checks = 0;
  int errors = 0;
  bit chk_on = 1'b0;
  string act_tag = "R12";

  always #2.5 clk = ~clk;

  pwm_fault_stage i_pwm_fault_stage (
    .clk(clk), .rst(rst), .pwm_in(pwm_in), .flt_in(flt_in),
    .cfg_sense(cfg_sense), .cfg_src_mask(cfg_src_mask), .cfg_latch(cfg_latch),
    .cfg_stretch(cfg_stretch), .cfg_min_period(cfg_min_period),
    .cfg_safe_val(cfg_safe_val), .cfg_out_en(cfg_out_en), .cfg_out_inv(cfg_out_inv),
    .fault_clr(fault_clr), .pwm_out(pwm_out), .flt_raw(flt_raw),
    .flt_active(flt_active), .flt_sticky(flt_sticky)
  );

  // Reference model, written from the requirements.
  logic [N-1:0] m_s1, m_s2, m_raw;
  logic m_act, m_latch, m_sticky;
  logic [PW-1:0] m_cnt;
  logic [M-1:0] m_out;

  function automatic logic [M-1:0] exp_pins(input logic act, input logic [M-1:0] gen,
      input logic [M-1:0] safe, input logic [M-1:0] inv, input logic [M-1:0] en);
    return en & ((act ? safe : gen) ^ inv);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_s1 <= '0; m_s2 <= '0; m_raw <= '0; m_act <= 1'b0;
      m_latch <= 1'b0; m_sticky <= 1'b0; m_cnt <= '0; m_out <= '0;
    end else begin
      logic hit;
      hit = |((m_s2 ^ cfg_sense) & cfg_src_mask);
      m_s1 <= flt_in;
      m_s2 <= m_s1;
      m_raw <= m_s2 ^ cfg_sense;
      m_out <= exp_pins(m_act, pwm_in, cfg_safe_val, cfg_out_inv, cfg_out_en);
      m_act <= hit || (cfg_latch && m_latch) || (cfg_stretch && m_cnt != 0);
      m_latch <= cfg_latch && (hit || (m_latch && !fault_clr));
      m_sticky <= hit || (m_sticky && !fault_clr);
      if (!cfg_stretch) m_cnt <= '0;
      else if (hit) m_cnt <= cfg_min_period;
      else if (m_cnt != 0) m_cnt <= m_cnt - 1'b1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      chk("R1 R2 raw", flt_raw, m_raw);
      chk({act_tag, " active"}, flt_active, m_act);
      chk("R8 sticky", flt_sticky, m_sticky);
      chk("R9 R10 R11 pins", pwm_out, m_out);
    end
  end

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk);
      pwm_in = M'($urandom);
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk); fault_clr = 1'b1;
    @(negedge clk); fault_clr = 1'b0;
  endtask

  initial begin
    #(LIMIT * 5.0);
    errors++;
    $display("FAIL watchdog expired, actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk); @(negedge clk);
    chk_on = 1'b1;                 // R12 reset state compared here
    tick(2);
    chk("R12 reset pins", pwm_out, 0);
    chk("R12 reset active", flt_active, 0);
    @(negedge clk); rst = 1'b0;
    cfg_out_en = 2'b11; cfg_safe_val = 2'b01;

    // R3: asserted but unmasked line
    act_tag = "R3"; cfg_src_mask = 4'b0001; flt_in = 4'b0010; tick(8);
    flt_in = 4'b0000; tick(4);

    // R2: sense flip on a masked line, low is asserted
    act_tag = "R2"; cfg_sense = 4'b0001; tick(6);
    cfg_sense = 4'b0000; tick(4);
    pulse_clr();

    // R4 and R1: follow mode
    act_tag = "R4 R1"; flt_in = 4'b0001; tick(5); flt_in = 4'b0000; tick(6);
    @(negedge clk); flt_in = 4'b0001; @(negedge clk); flt_in = 4'b0000; tick(6);

    // R5: latch, clear with and without a coincident fault
    act_tag = "R5"; cfg_latch = 1'b1;
    @(negedge clk); flt_in = 4'b0001; @(negedge clk); flt_in = 4'b0000; tick(10);
    flt_in = 4'b0001; tick(3); pulse_clr(); flt_in = 4'b0000; tick(6);
    pulse_clr(); tick(5); cfg_latch = 1'b0;

    // R6: stretch
    act_tag = "R6"; cfg_stretch = 1'b1; cfg_min_period = 16'd7;
    @(negedge clk); flt_in = 4'b0001; @(negedge clk); flt_in = 4'b0000; tick(14);
    flt_in = 4'b0001; tick(2); flt_in = 4'b0000; tick(4);
    flt_in = 4'b0001; @(negedge clk); flt_in = 4'b0000; tick(14);
    cfg_min_period = 16'd0; flt_in = 4'b0001; @(negedge clk); flt_in = 4'b0000; tick(6);

    // R7: latch plus stretch
    act_tag = "R7"; cfg_latch = 1'b1; cfg_min_period = 16'd9;
    @(negedge clk); flt_in = 4'b0001; @(negedge clk); flt_in = 4'b0000; tick(3);
    pulse_clr(); tick(14);
    flt_in = 4'b0001; @(negedge clk); flt_in = 4'b0000; tick(20);
    pulse_clr(); tick(4);
    cfg_latch = 1'b0; cfg_stretch = 1'b0;

    // R8: sticky clear and priority
    act_tag = "R8"; flt_in = 4'b0001; tick(3); pulse_clr(); flt_in = 4'b0000; tick(5);
    pulse_clr(); tick(3);

    // R9 R10 R11: output stage combos under a held fault and without
    act_tag = "R9";
    for (int k = 0; k < 16; k++) begin
      cfg_out_en = k[1:0]; cfg_out_inv = k[3:2]; cfg_safe_val = ~cfg_safe_val;
      flt_in = {3'b0, k[0]}; tick(5);
    end
    flt_in = '0; pulse_clr(); tick(4);

    // Constrained random phases
    act_tag = "R4 R5 R6 R7";
    for (int b = 0; b < 24; b++) begin
      cfg_sense = N'($urandom); cfg_src_mask = N'($urandom);
      cfg_latch = 1'($urandom); cfg_stretch = 1'($urandom);
      cfg_min_period = PW'($urandom % 12);
      cfg_safe_val = M'($urandom); cfg_out_en = M'($urandom); cfg_out_inv = M'($urandom);
      for (int c = 0; c < 150; c++) begin
        @(negedge clk);
        pwm_in = M'($urandom);
        if ($urandom % 8 == 0) flt_in[$urandom % N] = ~flt_in[$urandom % N];
        fault_clr = ($urandom % 20 == 0);
      end
    end
    fault_clr = 1'b0;
    tick(3);
    chk_on = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule